// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block keeps the transmit and receive error counts of a CAN node and turns them into the node's fault-confinement state. The protocol logic reports what happened on the bus as one-cycle strobes: a transmit error, a receive error, a good transmit, a good receive, and the detection of a run of eleven recessive bits. The block updates the two counts from these strobes. It then derives whether the node is error active, error passive or bus off.

From the counts and the state it builds a status word of warning, passive and bus-off flags. It raises a one-cycle error interrupt whenever the node newly enters one of these conditions. It also tells the frame logic which kind of error frame it may send: an active one, a passive one, or none at all while the node is bus off. Leaving bus off takes 128 recessive-idle runs. After that the node restarts error active with both counts cleared.

Top module: `can_fault_tracker`

## Requirements
- R1: After reset both counts are 0, the node state is error active (node_state_o = 0), status_o is 0, err_irq_o is 0 and err_frame_o is active (1).
- R2: A transmit error adds 8 to the transmit count and a receive error adds 1 to the receive count. A good transmit or good receive subtracts 1 from the matching count, but never below 0. When an error and a good-transfer strobe reach the same counter in one cycle, the error wins. All updates are visible on the outputs one clock after the strobe.
- R3: The receive count saturates at 255: a receive error at 255 leaves it at 255.
- R4: The node state is error passive (node_state_o = 1) while either count is 128 or more, provided the node is not bus off. It is error active (0) once both counts are below 128.
- R5: The node goes bus off (node_state_o = 2, status_o bit 13 set) when the transmit count exceeds 255. While bus off, all four count strobes are ignored and both counts hold.
- R6: Only idle-run strobes received while bus off are counted. The 128th such strobe returns the node to error active and clears both counts. Idle-run strobes outside bus off have no effect.
- R7: err_frame_o is 1 (active error frame) in error active, 2 (passive error frame) in error passive and 0 (send nothing) in bus off.
- R8: status_o bit 12 (transmit passive) is set while the transmit count is in 128..255. Bit 11 (receive passive) is set while the receive count is 128 or more.
- R9: status_o bit 10 (transmit warning) is set only while the transmit count is in 96..127. Bit 9 (receive warning) sets when the receive count is in 96..127 and clears only when the receive count drops below 96.
- R10: status_o bit 8 (combined warning) is set while at least one count is 96 or more, and clear when both are below 96.
- R11: err_irq_o, mirrored in status_o bit 5, is high for exactly one cycle when any of bus off, transmit passive, receive passive, transmit warning or receive warning becomes set. It stays low while these conditions persist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err_i | input | 1 | Transmit error strobe |
| rx_err_i | input | 1 | Receive error strobe |
| tx_ok_i | input | 1 | Good transmit strobe |
| rx_ok_i | input | 1 | Good receive strobe |
| idle_run_i | input | 1 | Strobe: eleven consecutive recessive bits seen |
| tx_cnt_o | output | 9 | Transmit error count |
| rx_cnt_o | output | 8 | Receive error count |
| node_state_o | output | 2 | 0 error active, 1 error passive, 2 bus off |
| err_frame_o | output | 2 | 0 none, 1 active error frame, 2 passive error frame |
| err_irq_o | output | 1 | One-cycle error interrupt pulse |
| status_o | output | 16 | Status flags: bits 13, 12, 11, 10, 9, 8, 5 as in R5 and R8 to R11 |

## Verification
A wrong count appears on tx_cnt_o or rx_cnt_o one clock after the strobe that caused it. A wrongly derived state or flag appears on node_state_o, err_frame_o and status_o in that same cycle, since the state and the flags follow the count outputs with no further delay. A miscounted recovery counter shows only when bus off ends, possibly many strobes later. For that reason the bench sends idle runs before bus off and checks at the 127th and 128th counted run. A stale edge-detect register shows as a missing or repeated interrupt in the cycle after a threshold crossing.

// File: rtl/can_fc_pkg.sv
// Package: shared types and status-word layout for the CAN fault
// confinement tracker. Assumes a 16-bit status word.
package can_fc_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_PASSIVE = 2'd1,
        ST_BUSOFF  = 2'd2
    } fc_state_e;

    typedef enum logic [1:0] {
        FR_NONE    = 2'd0,
        FR_ACTIVE  = 2'd1,
        FR_PASSIVE = 2'd2
    } fc_frame_e;

    localparam int STATUS_W     = 16;
    localparam int BIT_BUSOFF   = 13;
    localparam int BIT_TX_PASS  = 12;
    localparam int BIT_RX_PASS  = 11;
    localparam int BIT_TX_WARN  = 10;
    localparam int BIT_RX_WARN  = 9;
    localparam int BIT_ANY_WARN = 8;
    localparam int BIT_IRQ      = 5;

endpackage

// File: rtl/fc_err_counter.sv
// Module: saturating error counter. An error strobe adds INC and
// saturates at MAX. A good-transfer strobe subtracts one and stops at
// zero. Error wins over good. hold_i freezes the count and clear_i
// zeroes it, with clear taking priority. Also exposes the next-cycle
// value so that later logic can stay aligned with the register.
module fc_err_counter #(
    parameter int WIDTH = 8,
    parameter int INC   = 1,
    parameter int MAX   = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_i,
    input  logic             ok_i,
    input  logic             hold_i,
    input  logic             clear_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic [WIDTH-1:0] cnt_next_o
);

    localparam logic [WIDTH:0] INC_W = (WIDTH+1)'(INC);
    localparam logic [WIDTH:0] MAX_W = (WIDTH+1)'(MAX);

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH:0]   sum;

    // Widened sum so that the saturation test cannot wrap.
    assign sum = {1'b0, cnt_q} + INC_W;

    // Select the next count from clear, hold, error and good strobes.
    always_comb begin
        cnt_next_o = cnt_q;
        if (clear_i) begin
            cnt_next_o = '0;
        end else if (hold_i) begin
            cnt_next_o = cnt_q;
        end else if (err_i) begin
            cnt_next_o = (sum > MAX_W) ? MAX_W[WIDTH-1:0] : sum[WIDTH-1:0];
        end else if (ok_i && (cnt_q != '0)) begin
            cnt_next_o = cnt_q - 1'b1;
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next_o;
    end

    assign cnt_o = cnt_q;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0 && ok_i && !err_i && !hold_i && !clear_i) |=> (cnt_o == '0)); // R2
    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == MAX_W[WIDTH-1:0] && err_i && !hold_i && !clear_i) |=> (cnt_o == MAX_W[WIDTH-1:0])); // R3
    AST_FROZEN_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !clear_i) |=> $stable(cnt_o)); // R5

endmodule

// File: rtl/fc_state_ctrl.sv
// Module: confinement state machine. Picks active, passive or bus off
// from the next-cycle counts. While bus off it counts idle-run strobes
// and signals recovery on the last one. Assumes that the counters
// consume hold_o and clear_o in the same cycle.
module fc_state_ctrl
    import can_fc_pkg::*;
#(
    parameter int TXW          = 9,
    parameter int RXW          = 8,
    parameter int PASS_LIM     = 128,
    parameter int BUSOFF_LIM   = 256,
    parameter int RECOVER_RUNS = 128
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           idle_run_i,
    input  logic [TXW-1:0] tx_cnt_i,
    input  logic [RXW-1:0] rx_cnt_i,
    input  logic [TXW-1:0] tx_next_i,
    input  logic [RXW-1:0] rx_next_i,
    output fc_state_e      state_o,
    output fc_frame_e      frame_o,
    output logic           hold_o,
    output logic           clear_o
);

    localparam int RUN_W = (RECOVER_RUNS > 1) ? $clog2(RECOVER_RUNS) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RECOVER_RUNS - 1);
    localparam logic [TXW:0] TX_PASS_W   = (TXW+1)'(PASS_LIM);
    localparam logic [RXW:0] RX_PASS_W   = (RXW+1)'(PASS_LIM);
    localparam logic [TXW:0] TX_BUSOFF_W = (TXW+1)'(BUSOFF_LIM);

    fc_state_e       state_q, state_d;
    logic [RUN_W-1:0] run_q;
    logic             in_busoff;

    assign in_busoff = (state_q == ST_BUSOFF);
    assign hold_o    = in_busoff;
    assign clear_o   = in_busoff && idle_run_i && (run_q == RUN_LAST);

    // Next state from recovery or from the next-cycle counts.
    always_comb begin
        state_d = state_q;
        if (in_busoff) begin
            if (clear_o) state_d = ST_ACTIVE;
        end else if ({1'b0, tx_next_i} >= TX_BUSOFF_W) begin
            state_d = ST_BUSOFF;
        end else if (({1'b0, tx_next_i} >= TX_PASS_W) || ({1'b0, rx_next_i} >= RX_PASS_W)) begin
            state_d = ST_PASSIVE;
        end else begin
            state_d = ST_ACTIVE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    // Idle-run counter, live only during bus off.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_o)          run_q <= '0;
        else if (in_busoff && idle_run_i) run_q <= run_q + 1'b1;
    end

    // Error frame permission per state.
    always_comb begin
        case (state_q)
            ST_ACTIVE:  frame_o = FR_ACTIVE;
            ST_PASSIVE: frame_o = FR_PASSIVE;
            default:    frame_o = FR_NONE;
        endcase
    end

    assign state_o = state_q;

    AST_BUSOFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_BUSOFF) |-> (frame_o == FR_NONE)); // R7
    AST_RECOVER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> (state_o == ST_ACTIVE && tx_cnt_i == '0 && rx_cnt_i == '0)); // R6
    AST_PASSIVE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_PASSIVE) |-> (({1'b0, tx_cnt_i} >= TX_PASS_W) || ({1'b0, rx_cnt_i} >= RX_PASS_W))); // R4
    AST_BUSOFF_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_BUSOFF) |-> ({1'b0, tx_cnt_i} >= TX_BUSOFF_W)); // R5

endmodule

// File: rtl/fc_flag_gen.sv
// Module: status flag and interrupt generator. Derives the warning and
// passive flags from the current counts. Keeps the receive warning as a
// register with one-sided clearing, loaded from the next-cycle receive
// count. Pulses the interrupt on a rising edge of any condition.
module fc_flag_gen
    import can_fc_pkg::*;
#(
    parameter int TXW        = 9,
    parameter int RXW        = 8,
    parameter int WARN_LIM   = 96,
    parameter int PASS_LIM   = 128,
    parameter int BUSOFF_LIM = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TXW-1:0]      tx_cnt_i,
    input  logic [RXW-1:0]      rx_cnt_i,
    input  logic [RXW-1:0]      rx_next_i,
    input  logic                busoff_i,
    output logic                irq_o,
    output logic [STATUS_W-1:0] status_o
);

    localparam int NCOND = 5;
    localparam logic [TXW:0] TX_WARN_W   = (TXW+1)'(WARN_LIM);
    localparam logic [TXW:0] TX_PASS_W   = (TXW+1)'(PASS_LIM);
    localparam logic [TXW:0] TX_BUSOFF_W = (TXW+1)'(BUSOFF_LIM);
    localparam logic [RXW:0] RX_WARN_W   = (RXW+1)'(WARN_LIM);
    localparam logic [RXW:0] RX_PASS_W   = (RXW+1)'(PASS_LIM);
    localparam logic [RXW:0] RX_BUSOFF_W = (RXW+1)'(BUSOFF_LIM);

    logic [TXW:0] tx_w;
    logic [RXW:0] rx_w, rxn_w;
    logic tx_warn, tx_pass, rx_pass, any_warn, rx_warn_q;
    logic [NCOND-1:0] cond, cond_q;

    assign tx_w  = {1'b0, tx_cnt_i};
    assign rx_w  = {1'b0, rx_cnt_i};
    assign rxn_w = {1'b0, rx_next_i};

    // Window flags from the current counts.
    assign tx_warn  = (tx_w >= TX_WARN_W) && (tx_w < TX_PASS_W);
    assign tx_pass  = (tx_w >= TX_PASS_W) && (tx_w < TX_BUSOFF_W);
    assign rx_pass  = (rx_w >= RX_PASS_W) && (rx_w < RX_BUSOFF_W);
    assign any_warn = (tx_w >= TX_WARN_W) || (rx_w >= RX_WARN_W);

    // Receive warning: set inside the window, cleared only below it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_warn_q <= 1'b0;
        end else if (rxn_w < RX_WARN_W) begin
            rx_warn_q <= 1'b0;
        end else if (rxn_w < RX_PASS_W) begin
            rx_warn_q <= 1'b1;
        end
    end

    assign cond = {busoff_i, tx_pass, rx_pass, tx_warn, rx_warn_q};

    // Previous conditions for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond;
    end

    assign irq_o = |(cond & ~cond_q);

    // Assemble the status word at its fixed bit positions.
    always_comb begin
        status_o               = '0;
        status_o[BIT_BUSOFF]   = busoff_i;
        status_o[BIT_TX_PASS]  = tx_pass;
        status_o[BIT_RX_PASS]  = rx_pass;
        status_o[BIT_TX_WARN]  = tx_warn;
        status_o[BIT_RX_WARN]  = rx_warn_q;
        status_o[BIT_ANY_WARN] = any_warn;
        status_o[BIT_IRQ]      = irq_o;
    end

    AST_IRQ_ON_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busoff_i) |-> irq_o); // R11
    AST_IRQ_ONE_SHOT_BUSOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (busoff_i && $past(busoff_i) && $stable(cond)) |-> !irq_o); // R11
    AST_RXWARN_LOW_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_w < RX_WARN_W) |-> !rx_warn_q); // R9
    AST_RXWARN_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_w >= RX_WARN_W) && (rx_w < RX_PASS_W)) |-> rx_warn_q); // R9

endmodule

// File: rtl/can_fault_tracker.sv
// Module: top of the CAN fault confinement tracker. Wires two error
// counters, the state controller and the flag generator together.
// Assumes single-cycle event strobes from the protocol logic.
module can_fault_tracker
    import can_fc_pkg::*;
#(
    parameter int TXW          = 9,
    parameter int RXW          = 8,
    parameter int TX_INC       = 8,
    parameter int RX_INC       = 1,
    parameter int WARN_LIM     = 96,
    parameter int PASS_LIM     = 128,
    parameter int BUSOFF_LIM   = 256,
    parameter int RECOVER_RUNS = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_err_i,
    input  logic                rx_err_i,
    input  logic                tx_ok_i,
    input  logic                rx_ok_i,
    input  logic                idle_run_i,
    output logic [TXW-1:0]      tx_cnt_o,
    output logic [RXW-1:0]      rx_cnt_o,
    output logic [1:0]          node_state_o,
    output logic [1:0]          err_frame_o,
    output logic                err_irq_o,
    output logic [STATUS_W-1:0] status_o
);

    localparam int TX_MAX = (1 << TXW) - 1;
    localparam int RX_MAX = (1 << RXW) - 1;

    logic [TXW-1:0] tx_cnt, tx_next;
    logic [RXW-1:0] rx_cnt, rx_next;
    logic           hold, clear;
    fc_state_e      state;
    fc_frame_e      frame;

    fc_err_counter #(.WIDTH(TXW), .INC(TX_INC), .MAX(TX_MAX)) u_tx_cnt (
        .clk(clk), .rst_n(rst_n), .err_i(tx_err_i), .ok_i(tx_ok_i),
        .hold_i(hold), .clear_i(clear), .cnt_o(tx_cnt), .cnt_next_o(tx_next)
    );

    fc_err_counter #(.WIDTH(RXW), .INC(RX_INC), .MAX(RX_MAX)) u_rx_cnt (
        .clk(clk), .rst_n(rst_n), .err_i(rx_err_i), .ok_i(rx_ok_i),
        .hold_i(hold), .clear_i(clear), .cnt_o(rx_cnt), .cnt_next_o(rx_next)
    );

    fc_state_ctrl #(
        .TXW(TXW), .RXW(RXW), .PASS_LIM(PASS_LIM),
        .BUSOFF_LIM(BUSOFF_LIM), .RECOVER_RUNS(RECOVER_RUNS)
    ) u_state (
        .clk(clk), .rst_n(rst_n), .idle_run_i(idle_run_i),
        .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
        .tx_next_i(tx_next), .rx_next_i(rx_next),
        .state_o(state), .frame_o(frame), .hold_o(hold), .clear_o(clear)
    );

    fc_flag_gen #(
        .TXW(TXW), .RXW(RXW), .WARN_LIM(WARN_LIM),
        .PASS_LIM(PASS_LIM), .BUSOFF_LIM(BUSOFF_LIM)
    ) u_flags (
        .clk(clk), .rst_n(rst_n), .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
        .rx_next_i(rx_next), .busoff_i(state == ST_BUSOFF),
        .irq_o(err_irq_o), .status_o(status_o)
    );

    assign tx_cnt_o     = tx_cnt;
    assign rx_cnt_o     = rx_cnt;
    assign node_state_o = state;
    assign err_frame_o  = frame;

endmodule

// File: tb/can_fault_tracker_tb.sv
`timescale 1ns/1ps
module can_fault_tracker_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_err = 1'b0, rx_err = 1'b0, tx_ok = 1'b0, rx_ok = 1'b0, idle = 1'b0;
    logic [8:0]  tx_cnt;
    logic [7:0]  rx_cnt;
    logic [1:0]  st, frame;
    logic        irq;
    logic [15:0] status;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    can_fault_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err), .rx_err_i(rx_err),
        .tx_ok_i(tx_ok), .rx_ok_i(rx_ok), .idle_run_i(idle),
        .tx_cnt_o(tx_cnt), .rx_cnt_o(rx_cnt), .node_state_o(st),
        .err_frame_o(frame), .err_irq_o(irq), .status_o(status)
    );

    // Event codes {tx_err, rx_err, tx_ok, rx_ok, idle}.
    localparam logic [4:0] E_TXE = 5'b10000, E_RXE = 5'b01000,
                           E_TXO = 5'b00100, E_RXO = 5'b00010,
                           E_IDL = 5'b00001;

    // Vector: {event[4:0], tx[8:0], rx[7:0], state[1:0], status[15:0]}.
    localparam int NVEC = 7;
    localparam logic [39:0] VEC [NVEC] = '{
        {5'b10000, 9'd8,  8'd0, 2'd0, 16'h0000},
        {5'b01000, 9'd8,  8'd1, 2'd0, 16'h0000},
        {5'b00110, 9'd7,  8'd0, 2'd0, 16'h0000},
        {5'b00010, 9'd7,  8'd0, 2'd0, 16'h0000},
        {5'b10100, 9'd15, 8'd0, 2'd0, 16'h0000},
        {5'b01010, 9'd15, 8'd1, 2'd0, 16'h0000},
        {5'b00001, 9'd15, 8'd1, 2'd0, 16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Check every output; frame and irq follow from state and status.
    task automatic chk_all(input string tag, input logic [8:0] etx, input logic [7:0] erx,
                           input logic [1:0] est, input logic [15:0] estat);
        logic [1:0] efr;
        efr = (est == 2'd0) ? 2'd1 : (est == 2'd1) ? 2'd2 : 2'd0;
        chk({tag, " tx"}, 32'(tx_cnt), 32'(etx));
        chk({tag, " rx"}, 32'(rx_cnt), 32'(erx));
        chk({tag, " state"}, 32'(st), 32'(est));
        chk({tag, " status"}, 32'(status), 32'(estat));
        chk({tag, " frame R7"}, 32'(frame), 32'(efr));
        chk({tag, " irq R11"}, 32'(irq), 32'(estat[5]));
    endtask

    // Apply an event for one clock, n times; sample 1 ns after the edge.
    task automatic step(input logic [4:0] ev, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            {tx_err, rx_err, tx_ok, rx_ok, idle} = ev;
            @(posedge clk);
            #1;
            {tx_err, rx_err, tx_ok, rx_ok, idle} = 5'b0;
        end
    endtask

    initial begin
        #(20000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_all("R1 reset", 9'd0, 8'd0, 2'd0, 16'h0000);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk_all("R1 after release", 9'd0, 8'd0, 2'd0, 16'h0000);

        // R2 counter rules and R6 idle ignored outside bus off
        for (int v = 0; v < NVEC; v++) begin
            step(VEC[v][39:35], 1);
            chk_all($sformatf("R2 vec%0d", v), VEC[v][34:26], VEC[v][25:18],
                    VEC[v][17:16], VEC[v][15:0]);
        end

        step(E_IDL, 3);
        chk_all("R6 idle in active", 9'd15, 8'd1, 2'd0, 16'h0000);
        step(E_TXE, 10);
        chk_all("R9 tx 95", 9'd95, 8'd1, 2'd0, 16'h0000);
        step(E_TXE, 1);
        chk_all("R9 R10 R11 tx 103 warn", 9'd103, 8'd1, 2'd0, 16'h0520);
        step(E_TXO, 1);
        chk_all("R11 no repeat tx 102", 9'd102, 8'd1, 2'd0, 16'h0500);
        step(E_TXE, 3);
        chk_all("R9 tx 126", 9'd126, 8'd1, 2'd0, 16'h0500);
        step(E_TXE, 1);
        chk_all("R4 R8 tx 134 passive", 9'd134, 8'd1, 2'd1, 16'h1120);
        step(E_TXO, 7);
        chk_all("R4 tx 127 back active", 9'd127, 8'd1, 2'd0, 16'h0520);
        step(E_TXE, 1);
        chk_all("R8 tx 135", 9'd135, 8'd1, 2'd1, 16'h1120);
        step(E_TXE, 15);
        chk_all("R8 tx 255", 9'd255, 8'd1, 2'd1, 16'h1100);
        step(E_TXE, 1);
        chk_all("R5 bus off 263", 9'd263, 8'd1, 2'd2, 16'h2120);
        step(5'b11110, 1);
        chk_all("R5 strobes ignored", 9'd263, 8'd1, 2'd2, 16'h2100);
        step(E_TXO, 2);
        chk_all("R5 tx ok ignored", 9'd263, 8'd1, 2'd2, 16'h2100);
        step(E_IDL, 127);
        chk_all("R6 127 runs", 9'd263, 8'd1, 2'd2, 16'h2100);
        step(E_IDL, 1);
        chk_all("R6 recovered", 9'd0, 8'd0, 2'd0, 16'h0000);

        // Receive side
        step(E_RXE, 95);
        chk_all("R9 rx 95", 9'd0, 8'd95, 2'd0, 16'h0000);
        step(E_RXE, 1);
        chk_all("R9 R11 rx 96 warn", 9'd0, 8'd96, 2'd0, 16'h0320);
        step(E_RXE, 32);
        chk_all("R4 R8 rx 128 passive", 9'd0, 8'd128, 2'd1, 16'h0B20);
        step(E_RXO, 1);
        chk_all("R4 rx 127 active", 9'd0, 8'd127, 2'd0, 16'h0300);
        step(E_RXE, 1);
        chk_all("R11 rx 128 again", 9'd0, 8'd128, 2'd1, 16'h0B20);
        step(E_RXE, 127);
        chk_all("R9 rx 255 warn kept", 9'd0, 8'd255, 2'd1, 16'h0B00);
        step(E_RXE, 1);
        chk_all("R3 rx saturates", 9'd0, 8'd255, 2'd1, 16'h0B00);
        step(E_RXO, 159);
        chk_all("R9 rx 96", 9'd0, 8'd96, 2'd0, 16'h0300);
        step(E_RXO, 1);
        chk_all("R9 R10 rx 95 clear", 9'd0, 8'd95, 2'd0, 16'h0000);
        step(E_TXE, 12);
        chk_all("R10 tx 96 rx 95", 9'd96, 8'd95, 2'd0, 16'h0520);
        step(E_TXO, 1);
        chk_all("R10 both below", 9'd95, 8'd95, 2'd0, 16'h0000);

        // R1 reset from a busy state
        step(E_TXE, 6);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        chk_all("R1 mid-run reset", 9'd0, 8'd0, 2'd0, 16'h0000);
        @(negedge clk) rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule